// File: doc/BRIEF.md
# Codec Response Ring Writer

This block takes responses from codecs one at a time and stores them in a circular ring in system memory. Each response is a 32-bit word with a 4-bit codec address and a flag that marks it as unsolicited. For each response the block writes two words back to back: first the response word, then an extended word that carries the unsolicited flag and the codec address. The slot index runs modulo 256 and moves forward before each entry is written. The published write pointer changes only after the memory port has acknowledged both words.

The block counts the entries it has written since software last acknowledged the interrupt. It sets an interrupt status bit when that count reaches a programmed threshold, or when the command ring has drained. The status bit is set only while interrupts are enabled. When software clears the status bit, the count returns to zero and the block sends a one-cycle pulse that restarts command fetching.

When software has armed the immediate path, the next response goes into a holding register and is not written to memory. The immediate status byte then shows that the result is valid and which codec produced it.

Top module: `rrw_ring_writer`

## Requirements
- R1: Only one response is in flight at a time. `rsp_ready_o` is low while an entry is being written, and the memory request holds its address and data until it is acknowledged.
- R2: Let wp be the current pointer. An entry goes to slot (wp+1) mod 256. The first word is written at `ring_base_i` + 8·slot, and the second word follows at +4 after the first is acknowledged.
- R3: The first word of an entry is the response. The second word has bit 4 set when the response is unsolicited, bits 3:0 equal to the codec address, and all other bits zero.
- R4: `wp_o` takes the new slot value on the clock edge that accepts the acknowledgement of the second word, and at no other time except a pointer reset.
- R5: A response accepted with `dma_en_i` low and the immediate path not armed is dropped. No memory request is made, and the pointer and count are left unchanged.
- R6: Each entry written increments `rsp_cnt_o`. If the new count equals `rsp_thresh_i` and `irq_en_i` is high, `irq_sts_o` is set.
- R7: If `cmd_empty_i` is high when an entry completes and `irq_en_i` is high, `irq_sts_o` is set. With `irq_en_i` low, `irq_sts_o` stays as it was.
- R8: A pulse on `sts_clr_i` while `irq_sts_o` is set clears it, sets `rsp_cnt_o` to zero, and raises `fetch_restart_o` for exactly one cycle. A pulse while `irq_sts_o` is already clear changes nothing and gives no restart pulse.
- R9: A pulse on `wp_rst_i` sets `wp_o` to zero, so the next entry lands in slot 1.
- R10: A response accepted while the immediate path is armed is stored in `imm_rsp_o` and not written to memory. In `imm_sts_o`, bit 0 (busy) clears, bit 1 (valid) sets, and bits 7:4 take the codec address. Bits 3:2 are always zero.
- R11: `imm_busy_set_i` sets bit 0 of `imm_sts_o`. `imm_valid_clr_i` clears bit 1 and leaves the codec field unchanged.
- R12: The slot index wraps from 255 to 0, so that entry is written at `ring_base_i` itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rsp_valid_i | input | 1 | Response offered |
| rsp_ready_o | output | 1 | Block can take a response |
| rsp_data_i | input | 32 | Response word |
| rsp_cad_i | input | 4 | Codec address |
| rsp_unsol_i | input | 1 | Response is unsolicited |
| dma_en_i | input | 1 | Ring writing enabled |
| irq_en_i | input | 1 | Status setting enabled |
| ring_base_i | input | 32 | Ring base address |
| rsp_thresh_i | input | 8 | Coalescing count |
| cmd_empty_i | input | 1 | Command ring is drained |
| wp_rst_i | input | 1 | Pointer reset pulse |
| sts_clr_i | input | 1 | Write-one-to-clear of interrupt status |
| imm_busy_set_i | input | 1 | Arm the immediate path |
| imm_valid_clr_i | input | 1 | Clear the immediate valid flag |
| mem_req_o | output | 1 | Memory write request |
| mem_addr_o | output | 32 | Memory write byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory write accepted |
| wp_o | output | 8 | Ring write pointer |
| rsp_cnt_o | output | 8 | Entries since last acknowledge |
| irq_sts_o | output | 1 | Interrupt status |
| fetch_restart_o | output | 1 | One-cycle command fetch restart |
| imm_rsp_o | output | 32 | Immediate response register |
| imm_sts_o | output | 8 | Immediate status: busy bit 0, valid bit 1, codec 7:4 |

## Verification
A dropped response or an immediate capture is complete on the same edge that accepts it, so its effects are checked on the falling edge that follows. A ring entry takes at least two more edges, one for each acknowledged word, and the memory model adds a random wait of 0 to 2 cycles before each acknowledgement. The bench therefore waits until `rsp_ready_o` is high again before it compares the pointer, the count, the status and the two logged writes. Status clears, pointer resets and immediate arming are registered, so their results are sampled on the falling edge after the rising edge that takes the pulse.

// File: rtl/rrw_pkg.sv
package rrw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WORD0 = 2'd1,
    ST_WORD1 = 2'd2
  } wr_state_e;

  localparam int IMM_BUSY_BIT  = 0;
  localparam int IMM_VALID_BIT = 1;
  localparam int IMM_CAD_LSB   = 4;
  localparam int UNSOL_BIT     = 4;
endpackage

// File: rtl/rrw_entry_writer.sv
module rrw_entry_writer
  import rrw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PTR_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DATA_W-1:0] word0_i,
  input  logic [DATA_W-1:0] word1_i,
  input  logic              wp_rst_i,
  input  logic              mem_ack_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [PTR_W-1:0]  wp_o
);
  localparam int WORD_BYTES  = DATA_W / 8;
  localparam int ENTRY_SHIFT = $clog2(2 * WORD_BYTES);
  localparam int OFF_W       = PTR_W + ENTRY_SHIFT;

  wr_state_e         state_q;
  logic [PTR_W-1:0]  wp_q, slot_q;
  logic [ADDR_W-1:0] base_q;
  logic [DATA_W-1:0] w0_q, w1_q;
  logic [ADDR_W-1:0] entry_off, word_off;

  assign done_o    = (state_q == ST_WORD1) && mem_ack_i;
  assign busy_o    = (state_q != ST_IDLE);
  assign mem_req_o = busy_o;
  assign wp_o      = wp_q;

  assign entry_off   = {{(ADDR_W-OFF_W){1'b0}}, slot_q, {ENTRY_SHIFT{1'b0}}};
  assign word_off    = (state_q == ST_WORD1) ? ADDR_W'(WORD_BYTES) : '0;
  assign mem_addr_o  = base_q + entry_off + word_off;
  assign mem_wdata_o = (state_q == ST_WORD1) ? w1_q : w0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      wp_q    <= '0;
      slot_q  <= '0;
      base_q  <= '0;
      w0_q    <= '0;
      w1_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_WORD0;
          slot_q  <= wp_q + 1'b1;   // pre-increment, wraps modulo 2**PTR_W
          base_q  <= base_i;
          w0_q    <= word0_i;
          w1_q    <= word1_i;
        end
        ST_WORD0: if (mem_ack_i) state_q <= ST_WORD1;
        ST_WORD1: if (mem_ack_i) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
      if (wp_rst_i)    wp_q <= '0;
      else if (done_o) wp_q <= slot_q;
    end
  end

  a_r1_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

  a_r4_ptr_moves_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(wp_q) && !$past(wp_rst_i)) |-> $past(state_q == ST_WORD1 && mem_ack_i));

  a_r2_second_word_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WORD0 && mem_ack_i) |=> (state_q == ST_WORD1 && mem_req_o));
endmodule

// File: rtl/rrw_coalesce.sv
module rrw_coalesce #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             entry_done_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             cmd_empty_i,
  input  logic             irq_en_i,
  input  logic             sts_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_sts_o,
  output logic             restart_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             sts_q, restart_q;
  logic             set_hit, do_clr;

  always_comb begin
    cnt_inc = cnt_q + 1'b1;
    set_hit = entry_done_i && irq_en_i && ((cnt_inc == thresh_i) || cmd_empty_i);
    // a set in the same cycle wins over the clear
    do_clr  = sts_clr_i && sts_q && !set_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      sts_q     <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      restart_q <= do_clr;
      if (do_clr)            cnt_q <= '0;
      else if (entry_done_i) cnt_q <= cnt_inc;
      if (set_hit)           sts_q <= 1'b1;
      else if (do_clr)       sts_q <= 1'b0;
    end
  end

  assign cnt_o     = cnt_q;
  assign irq_sts_o = sts_q;
  assign restart_o = restart_q;

  a_r6_set_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sts_q) |-> $past(irq_en_i && entry_done_i));

  a_r8_clear_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sts_q) |-> (restart_q && cnt_q == '0));

  a_r8_restart_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_q |=> !restart_q);

  a_r6_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(cnt_q) && !restart_q) |-> $past(entry_done_i));
endmodule

// File: rtl/rrw_imm_latch.sv
module rrw_imm_latch
  import rrw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CAD_W  = 4,
  localparam int STS_W = CAD_W + IMM_CAD_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_set_i,
  input  logic              valid_clr_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CAD_W-1:0]  cad_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] rsp_o,
  output logic [STS_W-1:0]  sts_o
);
  logic              busy_q, valid_q;
  logic [CAD_W-1:0]  cad_q;
  logic [DATA_W-1:0] rsp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      cad_q   <= '0;
      rsp_q   <= '0;
    end else if (capture_i) begin
      rsp_q   <= data_i;
      busy_q  <= 1'b0;
      valid_q <= 1'b1;
      cad_q   <= cad_i;
    end else begin
      if (busy_set_i)  busy_q  <= 1'b1;
      if (valid_clr_i) valid_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign rsp_o  = rsp_q;
  assign sts_o  = {cad_q, {(IMM_CAD_LSB-2){1'b0}}, valid_q, busy_q};

  a_r10_valid_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_q) |-> (!busy_q && $past(busy_q)));

  a_r10_capture_only_armed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_i |-> busy_q);
endmodule

// File: rtl/rrw_ring_writer.sv
module rrw_ring_writer
  import rrw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PTR_W  = 8,
  parameter int CNT_W  = 8,
  parameter int CAD_W  = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rsp_valid_i,
  output logic                       rsp_ready_o,
  input  logic [DATA_W-1:0]          rsp_data_i,
  input  logic [CAD_W-1:0]           rsp_cad_i,
  input  logic                       rsp_unsol_i,
  input  logic                       dma_en_i,
  input  logic                       irq_en_i,
  input  logic [ADDR_W-1:0]          ring_base_i,
  input  logic [CNT_W-1:0]           rsp_thresh_i,
  input  logic                       cmd_empty_i,
  input  logic                       wp_rst_i,
  input  logic                       sts_clr_i,
  input  logic                       imm_busy_set_i,
  input  logic                       imm_valid_clr_i,
  output logic                       mem_req_o,
  output logic [ADDR_W-1:0]          mem_addr_o,
  output logic [DATA_W-1:0]          mem_wdata_o,
  input  logic                       mem_ack_i,
  output logic [PTR_W-1:0]           wp_o,
  output logic [CNT_W-1:0]           rsp_cnt_o,
  output logic                       irq_sts_o,
  output logic                       fetch_restart_o,
  output logic [DATA_W-1:0]          imm_rsp_o,
  output logic [CAD_W+IMM_CAD_LSB-1:0] imm_sts_o
);
  logic              accept, wr_busy, entry_done, imm_busy;
  logic              start_entry, imm_capture;
  logic [DATA_W-1:0] ext_word;

  assign rsp_ready_o = !wr_busy;
  assign accept      = rsp_valid_i && rsp_ready_o;
  assign imm_capture = accept && imm_busy;
  assign start_entry = accept && !imm_busy && dma_en_i;
  assign ext_word    = {{(DATA_W-UNSOL_BIT-1){1'b0}}, rsp_unsol_i,
                        {(UNSOL_BIT-CAD_W){1'b0}}, rsp_cad_i};

  rrw_entry_writer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)) u_writer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_entry),
    .base_i      (ring_base_i),
    .word0_i     (rsp_data_i),
    .word1_i     (ext_word),
    .wp_rst_i    (wp_rst_i),
    .mem_ack_i   (mem_ack_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .busy_o      (wr_busy),
    .done_o      (entry_done),
    .wp_o        (wp_o)
  );

  rrw_coalesce #(.CNT_W(CNT_W)) u_coalesce (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .entry_done_i (entry_done),
    .thresh_i     (rsp_thresh_i),
    .cmd_empty_i  (cmd_empty_i),
    .irq_en_i     (irq_en_i),
    .sts_clr_i    (sts_clr_i),
    .cnt_o        (rsp_cnt_o),
    .irq_sts_o    (irq_sts_o),
    .restart_o    (fetch_restart_o)
  );

  rrw_imm_latch #(.DATA_W(DATA_W), .CAD_W(CAD_W)) u_imm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_set_i  (imm_busy_set_i),
    .valid_clr_i (imm_valid_clr_i),
    .capture_i   (imm_capture),
    .data_i      (rsp_data_i),
    .cad_i       (rsp_cad_i),
    .busy_o      (imm_busy),
    .rsp_o       (imm_rsp_o),
    .sts_o       (imm_sts_o)
  );

  a_r1_single_in_flight: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !rsp_ready_o);

  a_r5_drop_no_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !dma_en_i && !imm_busy) |=> (!mem_req_o && $stable(wp_o)));

  a_r10_imm_no_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_capture |=> !mem_req_o);
endmodule

// File: tb/rrw_ring_writer_tb_top.sv
module rrw_ring_writer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rsp_valid = 0, rsp_unsol = 0, dma_en = 0, irq_en = 0, cmd_empty = 0;
  logic        wp_rst = 0, sts_clr = 0, imm_set = 0, imm_clr = 0, mem_ack = 0;
  logic [31:0] rsp_data = 0, ring_base = 32'h8000_1000;
  logic [3:0]  rsp_cad = 0;
  logic [7:0]  thresh = 8'd4;
  logic        rsp_ready, mem_req, irq_sts, restart;
  logic [31:0] mem_addr, mem_wdata, imm_rsp;
  logic [7:0]  wp, cnt, imm_sts;

  int n_cmp = 0, n_bad = 0;
  int log_n = 0;
  logic [31:0] log_addr [0:2047];
  logic [31:0] log_data [0:2047];
  int unsigned ack_wait = 0;

  logic [7:0] exp_wp = 0, exp_cnt = 0;
  logic       exp_sts = 0, imm_armed = 0;

  always #4 clk = ~clk;

  rrw_ring_writer dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .rsp_valid_i(rsp_valid), .rsp_ready_o(rsp_ready),
    .rsp_data_i(rsp_data), .rsp_cad_i(rsp_cad), .rsp_unsol_i(rsp_unsol),
    .dma_en_i(dma_en), .irq_en_i(irq_en), .ring_base_i(ring_base),
    .rsp_thresh_i(thresh), .cmd_empty_i(cmd_empty),
    .wp_rst_i(wp_rst), .sts_clr_i(sts_clr),
    .imm_busy_set_i(imm_set), .imm_valid_clr_i(imm_clr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .wp_o(wp), .rsp_cnt_o(cnt), .irq_sts_o(irq_sts), .fetch_restart_o(restart),
    .imm_rsp_o(imm_rsp), .imm_sts_o(imm_sts)
  );

  // memory model: random wait, logs each accepted write
  initial forever begin
    @(negedge clk);
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (ack_wait == 0) begin
        if (log_n < 2048) begin
          log_addr[log_n] = mem_addr;
          log_data[log_n] = mem_wdata;
        end
        log_n++;
        mem_ack  = 1'b1;
        ack_wait = $urandom % 3;
      end else ack_wait--;
    end
  end

  function automatic logic [31:0] ext_of(logic u, logic [3:0] c);
    return {27'd0, u, c};
  endfunction

  function automatic logic [31:0] slot_addr(logic [7:0] s);
    return ring_base + {21'd0, s, 3'd0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] d, input logic [3:0] c, input logic u);
    int n0;
    n0 = log_n;
    while (!rsp_ready) @(negedge clk);
    rsp_data = d; rsp_cad = c; rsp_unsol = u; rsp_valid = 1'b1;
    @(negedge clk);
    rsp_valid = 1'b0;
    if (mem_req) chk("R1 ready low during entry", {31'd0, rsp_ready}, 32'd0);
    while (!rsp_ready) @(negedge clk);
    if (imm_armed) begin
      imm_armed = 1'b0;
      chk("R10 imm response", imm_rsp, d);
      chk("R10 imm status", {24'd0, imm_sts}, {24'd0, c, 4'b0010});
      chk("R10 no memory write", log_n, n0);
    end else if (dma_en) begin
      exp_wp  = exp_wp + 8'd1;
      exp_cnt = exp_cnt + 8'd1;
      if (irq_en && ((exp_cnt == thresh) || cmd_empty)) exp_sts = 1'b1;
      chk("R2 two writes", log_n, n0 + 2);
      chk(exp_wp == 0 ? "R12 wrap addr" : "R2 word0 addr", log_addr[n0], slot_addr(exp_wp));
      chk("R2 word1 addr", log_addr[n0+1], slot_addr(exp_wp) + 32'd4);
      chk("R3 word0 data", log_data[n0], d);
      chk("R3 word1 data", log_data[n0+1], ext_of(u, c));
    end else begin
      chk("R5 dropped no write", log_n, n0);
    end
    chk("R4 pointer", {24'd0, wp}, {24'd0, exp_wp});
    chk("R6 count", {24'd0, cnt}, {24'd0, exp_cnt});
    chk("R7 status", {31'd0, irq_sts}, {31'd0, exp_sts});
  endtask

  task automatic clear_sts();
    logic had;
    had = exp_sts;
    sts_clr = 1'b1;
    @(negedge clk);
    sts_clr = 1'b0;
    if (had) exp_cnt = 8'd0;
    exp_sts = 1'b0;
    chk("R8 restart pulse", {31'd0, restart}, {31'd0, had});
    chk("R8 status cleared", {31'd0, irq_sts}, 32'd0);
    chk("R8 count", {24'd0, cnt}, {24'd0, exp_cnt});
    @(negedge clk);
    chk("R8 restart one cycle", {31'd0, restart}, 32'd0);
  endtask

  task automatic arm_imm();
    imm_set = 1'b1;
    @(negedge clk);
    imm_set = 1'b0;
    imm_armed = 1'b1;
    chk("R11 busy set", {31'd0, imm_sts[0]}, 32'd1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset ready", {31'd0, rsp_ready}, 32'd1);
    chk("R4 reset wp", {24'd0, wp}, 32'd0);
    chk("R6 reset cnt", {24'd0, cnt}, 32'd0);
    chk("R10 reset imm", {24'd0, imm_sts}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle no req", {31'd0, mem_req}, 32'd0);

    // directed: threshold reach
    dma_en = 1; irq_en = 1; cmd_empty = 0; thresh = 8'd3;
    send(32'hDEAD_0001, 4'h2, 1'b0);
    send(32'hDEAD_0002, 4'hF, 1'b1);
    chk("R6 below thresh", {31'd0, irq_sts}, 32'd0);
    send(32'hDEAD_0003, 4'h5, 1'b0);
    chk("R6 thresh hit", {31'd0, irq_sts}, 32'd1);
    clear_sts();
    clear_sts();   // R8 clear while clear: no pulse
    // R7 drained command ring, and enable gating
    cmd_empty = 1; irq_en = 0;
    send(32'h1111_2222, 4'h1, 1'b1);
    chk("R7 gated by enable", {31'd0, irq_sts}, 32'd0);
    irq_en = 1;
    send(32'h3333_4444, 4'h3, 1'b0);
    chk("R7 empty sets", {31'd0, irq_sts}, 32'd1);
    clear_sts();
    cmd_empty = 0;
    // R5 drop
    dma_en = 0;
    send(32'h5555_6666, 4'h7, 1'b0);
    dma_en = 1;
    // R9 pointer reset
    wp_rst = 1; @(negedge clk); wp_rst = 0;
    exp_wp = 0;
    chk("R9 wp reset", {24'd0, wp}, 32'd0);
    send(32'h7777_8888, 4'h9, 1'b1);
    // R10/R11 immediate path
    arm_imm();
    send(32'hCAFE_F00D, 4'hA, 1'b1);
    imm_clr = 1; @(negedge clk); imm_clr = 0;
    chk("R11 valid clear keeps cad", {24'd0, imm_sts}, {24'd0, 8'hA0});

    // constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 120; i++) begin
      dma_en    = ($urandom % 8) != 0;
      irq_en    = ($urandom % 2) != 0;
      cmd_empty = ($urandom % 5) == 0;
      thresh    = 8'($urandom % 8 + 1);
      if ($urandom % 10 == 0) arm_imm();
      send($urandom, 4'($urandom), 1'($urandom));
      if ($urandom % 6 == 0) clear_sts();
    end

    // R12 wrap to slot 0
    dma_en = 1; irq_en = 0; cmd_empty = 0;
    while (exp_wp != 8'd255) send($urandom, 4'($urandom), 1'($urandom));
    send(32'hABCD_0000, 4'h4, 1'b0);
    chk("R12 wrapped wp", {24'd0, wp}, 32'd0);
    finish_run();
  end
endmodule